// File: doc/BRIEF.md
# Serial Receive Start and Clock Strobe Controller

This block is the timing front end of a synchronous serial receiver. It runs entirely on a fast system clock. It takes the candidate serial clocks (an internally divided clock, the transmitter's clock and the receive clock pin) and a frame-sync line as plain inputs, and resynchronises each of them. It then derives everything the receive shifter needs from that one clock domain.

A configuration field picks one of the clock sources. A second field can gate that clock so that it runs only while frame sync sits at a chosen level. A polarity bit decides which edge of the gated clock produces the sample strobe and which produces the shift strobe.

A separate selector picks the start condition. The transfer can start continuously, on the transmitter starting, on a frame-sync level, on a frame-sync edge, or on a compare match. The block emits a one-cycle start pulse and then ignores new triggers until the transfer-complete pulse arrives. A clock-output mode drives the receive clock pin either never, always, or only for the span of a transfer. In each case it also drives the matching pin-enable.

Top module: `rx_start_ctrl`

## Requirements
- R1: With start code 0 and `rx_enable` high, `start_pulse` is asserted in any cycle where no transfer is open. This includes the cycle right after `xfer_done` closes a transfer.
- R2: Start code 1 fires `start_pulse` in the same cycle as `tx_start_pulse`. Start code 8 fires it in the same cycle as `cmp0_pulse`.
- R3: Start code 2 fires while the synchronised frame sync is 0. Start code 3 fires while it is 1.
- R4: Start code 4 fires on a 1-to-0 change of the synchronised frame sync, and code 5 on a 0-to-1 change. Codes 6 and 7 fire on either change. The synchronised frame sync trails `fsync_in` by two system clocks.
- R5: Start codes 9 to 15 never produce `start_pulse`.
- R6: `start_pulse` lasts one cycle. After it, triggers are ignored until a cycle in which `xfer_done` is high has passed.
- R7: With `rx_enable` low, no start occurs, and any open transfer is closed at the next edge.
- R8: `cfg_src` selects the receive clock: 0 selects `div_clk_in`, 1 selects `tx_clk_in` and 2 selects `rx_clk_pin_in`, each resynchronised with the same two-clock latency. Code 3 holds the clock low, so no strobes occur.
- R9: `cfg_gate` 0 leaves the clock ungated. Code 1 passes it only while the synchronised frame sync is 0, and code 2 only while it is 1. Code 3 blocks it.
- R10: With `cfg_inv` = 1, `sample_stb` marks rising edges of the gated clock and `shift_stb` marks falling edges. With `cfg_inv` = 0 the two are swapped. Each strobe is one cycle wide.
- R11: `cfg_clkout` 0 or 3 keeps `rx_clk_oe` and `rx_clk_out` low. Code 1 holds `rx_clk_oe` high and drives `rx_clk_out` with the gated clock, whatever the value of `cfg_inv`.
- R12: With `cfg_clkout` 2, `rx_clk_oe` is high from the start-pulse cycle until the transfer closes. `rx_clk_out` carries the gated clock inside that window and is 0 outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable |
| cfg_start | input | 4 | Start condition code |
| cfg_gate | input | 2 | Clock gating code |
| cfg_inv | input | 1 | Strobe edge polarity |
| cfg_src | input | 2 | Receive clock source code |
| cfg_clkout | input | 2 | Clock pin output mode |
| div_clk_in | input | 1 | Divided clock source |
| tx_clk_in | input | 1 | Transmit clock source |
| rx_clk_pin_in | input | 1 | Receive clock pin, input path |
| fsync_in | input | 1 | Frame-sync line |
| tx_start_pulse | input | 1 | Transmitter start event |
| cmp0_pulse | input | 1 | Compare-match event |
| xfer_done | input | 1 | Transfer-complete pulse |
| start_pulse | output | 1 | One-cycle start of receive transfer |
| sample_stb | output | 1 | Sample strobe |
| shift_stb | output | 1 | Shift strobe |
| rx_clk_out | output | 1 | Receive clock pin, output value |
| rx_clk_oe | output | 1 | Receive clock pin driver enable |

## Verification
The clock path is swept over every combination of source, gating, polarity and output mode. During each combination, three counter-driven clocks toggle at different rates and frame sync toggles as well. A source mix-up therefore shows as a strobe at the wrong cycle, and a polarity swap shows as sample and shift trading places. Gating errors show as strobes while frame sync is at the closed level. The start logic is swept over all sixteen start codes with a pseudo-random frame-sync waveform and random transmit-start, compare and done pulses, plus a window with the receiver disabled. This separates level triggers from edge triggers and one edge direction from the other. It also exposes triggers that leak through while a transfer is open, and reserved codes that start anyway.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int START_W = 4;
    localparam int GATE_W  = 2;
    localparam int SRC_W   = 2;
    localparam int CKO_W   = 2;

    localparam logic [START_W-1:0] ST_FREE    = 4'd0;
    localparam logic [START_W-1:0] ST_TXGO    = 4'd1;
    localparam logic [START_W-1:0] ST_LVL_LO  = 4'd2;
    localparam logic [START_W-1:0] ST_LVL_HI  = 4'd3;
    localparam logic [START_W-1:0] ST_FALL    = 4'd4;
    localparam logic [START_W-1:0] ST_RISE    = 4'd5;
    localparam logic [START_W-1:0] ST_TOGGLE  = 4'd6;
    localparam logic [START_W-1:0] ST_ANYEDGE = 4'd7;
    localparam logic [START_W-1:0] ST_CMP     = 4'd8;

    typedef enum logic [GATE_W-1:0] {
        GT_OPEN    = 2'd0,
        GT_WHEN_LO = 2'd1,
        GT_WHEN_HI = 2'd2,
        GT_RSVD    = 2'd3
    } gate_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_DIV  = 2'd0,
        SRC_TX   = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [CKO_W-1:0] {
        CKO_OFF   = 2'd0,
        CKO_FREE  = 2'd1,
        CKO_BURST = 2'd2,
        CKO_RSVD  = 2'd3
    } cko_e;

    // Sampled serial-side inputs, carried together through the synchroniser
    typedef struct packed {
        logic fs;
        logic pin_clk;
        logic tx_clk;
        logic div_clk;
    } smp_t;

    localparam int SMP_W = $bits(smp_t);

    function automatic logic pick_clk(input logic [SRC_W-1:0] src, input smp_t s);
        logic c;
        case (src_e'(src))
            SRC_DIV: c = s.div_clk;
            SRC_TX:  c = s.tx_clk;
            SRC_PIN: c = s.pin_clk;
            default: c = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic gate_open(input logic [GATE_W-1:0] g, input logic fs);
        logic o;
        case (gate_e'(g))
            GT_OPEN:    o = 1'b1;
            GT_WHEN_LO: o = ~fs;
            GT_WHEN_HI: o = fs;
            default:    o = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '0;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxs_clk_path.sv
module rxs_clk_path
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  smp_t              cur,
    input  logic [SRC_W-1:0]  src,
    input  logic [GATE_W-1:0] gate,
    input  logic              inv,
    output logic              gclk,
    output logic              sample_stb,
    output logic              shift_stb
);
    logic gclk_q;
    logic rise, fall;

    assign gclk = pick_clk(src, cur) & gate_open(gate, cur.fs);

    always_ff @(posedge clk) begin
        if (rst) gclk_q <= 1'b0;
        else     gclk_q <= gclk;
    end

    assign rise = gclk & ~gclk_q;
    assign fall = ~gclk & gclk_q;

    assign sample_stb = inv ? rise : fall;
    assign shift_stb  = inv ? fall : rise;
endmodule

// File: rtl/rxs_start_ctl.sv
module rxs_start_ctl
    import rxs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [START_W-1:0] sel,
    input  logic               fs_cur,
    input  logic               tx_go,
    input  logic               cmp_hit,
    input  logic               done,
    output logic               start,
    output logic               busy
);
    logic fs_q;
    logic trig;

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= fs_cur;
    end

    always_comb begin
        case (sel)
            ST_FREE:    trig = 1'b1;
            ST_TXGO:    trig = tx_go;
            ST_LVL_LO:  trig = ~fs_cur;
            ST_LVL_HI:  trig = fs_cur;
            ST_FALL:    trig = fs_q & ~fs_cur;
            ST_RISE:    trig = ~fs_q & fs_cur;
            ST_TOGGLE,
            ST_ANYEDGE: trig = fs_q ^ fs_cur;
            ST_CMP:     trig = cmp_hit;
            default:    trig = 1'b0;
        endcase
    end

    assign start = enable & ~busy & trig;

    always_ff @(posedge clk) begin
        if (rst || !enable) busy <= 1'b0;
        else if (start)     busy <= 1'b1;
        else if (done)      busy <= 1'b0;
    end
endmodule

// File: rtl/rx_start_ctrl.sv
module rx_start_ctrl
    import rxs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_enable,
    input  logic [3:0]   cfg_start,
    input  logic [1:0]   cfg_gate,
    input  logic         cfg_inv,
    input  logic [1:0]   cfg_src,
    input  logic [1:0]   cfg_clkout,
    input  logic         div_clk_in,
    input  logic         tx_clk_in,
    input  logic         rx_clk_pin_in,
    input  logic         fsync_in,
    input  logic         tx_start_pulse,
    input  logic         cmp0_pulse,
    input  logic         xfer_done,
    output logic         start_pulse,
    output logic         sample_stb,
    output logic         shift_stb,
    output logic         rx_clk_out,
    output logic         rx_clk_oe
);
    smp_t raw, cur;
    logic gclk;
    logic xfer_busy;

    always_comb begin
        raw.fs      = fsync_in;
        raw.pin_clk = rx_clk_pin_in;
        raw.tx_clk  = tx_clk_in;
        raw.div_clk = div_clk_in;
    end

    rxs_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cur)
    );

    rxs_clk_path u_clk (
        .clk        (clk),
        .rst        (rst),
        .cur        (cur),
        .src        (cfg_src),
        .gate       (cfg_gate),
        .inv        (cfg_inv),
        .gclk       (gclk),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

    rxs_start_ctl u_start (
        .clk     (clk),
        .rst     (rst),
        .enable  (rx_enable),
        .sel     (cfg_start),
        .fs_cur  (cur.fs),
        .tx_go   (tx_start_pulse),
        .cmp_hit (cmp0_pulse),
        .done    (xfer_done),
        .start   (start_pulse),
        .busy    (xfer_busy)
    );

    // Pin driver: output never inverted, idle level is low
    always_comb begin
        case (cko_e'(cfg_clkout))
            CKO_FREE: begin
                rx_clk_oe  = 1'b1;
                rx_clk_out = gclk;
            end
            CKO_BURST: begin
                rx_clk_oe  = start_pulse | xfer_busy;
                rx_clk_out = rx_clk_oe & gclk;
            end
            default: begin
                rx_clk_oe  = 1'b0;
                rx_clk_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rx_start_ctrl_chk.sv
module rx_start_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_enable,
    input logic [3:0] cfg_start,
    input logic [1:0] cfg_gate,
    input logic [1:0] cfg_clkout,
    input logic       start_pulse,
    input logic       sample_stb,
    input logic       shift_stb,
    input logic       rx_clk_out,
    input logic       rx_clk_oe
);
    p_single_start_r6: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    p_reserved_code_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_start > 4'd8) |-> !start_pulse);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && shift_stb));

    p_gate_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate == 2'd3 && $past(cfg_gate) == 2'd3) |-> (!sample_stb && !shift_stb));

    p_pin_input_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_clkout == 2'd0 || cfg_clkout == 2'd3) |-> (!rx_clk_oe && !rx_clk_out));

    p_burst_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (cfg_clkout == 2'd2 && !rx_clk_oe) |-> !rx_clk_out);

    p_burst_held_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(start_pulse) && $past(cfg_clkout) == 2'd2 && cfg_clkout == 2'd2 && rx_enable)
            |-> rx_clk_oe);
endmodule

bind rx_start_ctrl rx_start_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_enable   (rx_enable),
    .cfg_start   (cfg_start),
    .cfg_gate    (cfg_gate),
    .cfg_clkout  (cfg_clkout),
    .start_pulse (start_pulse),
    .sample_stb  (sample_stb),
    .shift_stb   (shift_stb),
    .rx_clk_out  (rx_clk_out),
    .rx_clk_oe   (rx_clk_oe)
);

// File: tb/rx_start_ctrl_bench.sv
module rx_start_ctrl_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       rx_enable;
    logic [3:0] cfg_start;
    logic [1:0] cfg_gate;
    logic       cfg_inv;
    logic [1:0] cfg_src;
    logic [1:0] cfg_clkout;
    logic       div_clk_in, tx_clk_in, rx_clk_pin_in, fsync_in;
    logic       tx_start_pulse, cmp0_pulse, xfer_done;
    logic       start_pulse, sample_stb, shift_stb, rx_clk_out, rx_clk_oe;

    rx_start_ctrl u_rx_start_ctrl (
        .clk(clk), .rst(rst), .rx_enable(rx_enable),
        .cfg_start(cfg_start), .cfg_gate(cfg_gate), .cfg_inv(cfg_inv),
        .cfg_src(cfg_src), .cfg_clkout(cfg_clkout),
        .div_clk_in(div_clk_in), .tx_clk_in(tx_clk_in),
        .rx_clk_pin_in(rx_clk_pin_in), .fsync_in(fsync_in),
        .tx_start_pulse(tx_start_pulse), .cmp0_pulse(cmp0_pulse),
        .xfer_done(xfer_done),
        .start_pulse(start_pulse), .sample_stb(sample_stb), .shift_stb(shift_stb),
        .rx_clk_out(rx_clk_out), .rx_clk_oe(rx_clk_oe)
    );

    int n_vec = 0;
    int n_bad = 0;

    // history of driven serial inputs: bit0 div, bit1 tx, bit2 pin, bit3 fs
    logic [3:0] h1, h2, h3;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        h3 = h2;
        h2 = h1;
        h1 = {fsync_in, rx_clk_pin_in, tx_clk_in, div_clk_in};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_enable = 1'b0;
        {div_clk_in, tx_clk_in, rx_clk_pin_in, fsync_in} = '0;
        {tx_start_pulse, cmp0_pulse, xfer_done} = '0;
        repeat (3) @(posedge clk);
        #2;
        h1 = '0; h2 = '0; h3 = '0;
        rst = 1'b0;
    endtask

    function automatic logic exp_gclk(input logic [3:0] h, input int src, input int gate);
        logic sc, ok;
        case (src)
            0: sc = h[0];
            1: sc = h[1];
            2: sc = h[2];
            default: sc = 1'b0;
        endcase
        case (gate)
            0: ok = 1'b1;
            1: ok = ~h[3];
            2: ok = h[3];
            default: ok = 1'b0;
        endcase
        return sc & ok;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cfg_start = 4'd0; cfg_gate = 2'd0; cfg_inv = 1'b0;
        cfg_src = 2'd0; cfg_clkout = 2'd0;
        do_reset();
        #1;
        // reset state
        check("R7", "reset start_pulse", start_pulse, 1'b0);
        check("R10", "reset sample_stb", sample_stb, 1'b0);
        check("R10", "reset shift_stb", shift_stb, 1'b0);
        check("R11", "reset rx_clk_oe", rx_clk_oe, 1'b0);

        // clock path: exhaustive over source, gating, polarity, pin mode
        for (int src = 0; src < 4; src++)
        for (int gate = 0; gate < 4; gate++)
        for (int inv = 0; inv < 2; inv++)
        for (int cko = 0; cko < 4; cko++) begin
            cfg_start = 4'd0; cfg_src = 2'(src); cfg_gate = 2'(gate);
            cfg_inv = 1'(inv); cfg_clkout = 2'(cko);
            do_reset();
            for (int k = 0; k < 32; k++) begin
                logic g2, g3, rs, fl, es, eh, eo, ec;
                string tg;
                tick();
                div_clk_in    = k[1];
                tx_clk_in     = k[2];
                rx_clk_pin_in = k[0] ^ k[3];
                fsync_in      = k[3] ^ k[4];
                #1;
                g2 = exp_gclk(h2, src, gate);
                g3 = exp_gclk(h3, src, gate);
                rs = g2 & ~g3;
                fl = ~g2 & g3;
                es = inv ? rs : fl;
                eh = inv ? fl : rs;
                eo = (cko == 1);
                ec = (cko == 1) ? g2 : 1'b0;
                tg = (src == 3) ? "R8" : ((gate != 0) ? "R9" : "R10");
                check(tg, "sample_stb", sample_stb, es);
                check(tg, "shift_stb", shift_stb, eh);
                check("R11", "rx_clk_oe", rx_clk_oe, eo);
                check("R11", "rx_clk_out", rx_clk_out, ec);
            end
        end

        // start logic: all sixteen start codes, burst pin mode
        for (int code = 0; code < 16; code++) begin
            logic [15:0] lf;
            logic mbusy;
            cfg_start = 4'(code); cfg_src = 2'd0; cfg_gate = 2'd0;
            cfg_inv = 1'b0; cfg_clkout = 2'd2;
            do_reset();
            lf = 16'hACE1 ^ 16'(code * 16'h1357);
            mbusy = 1'b0;
            for (int i = 0; i < 180; i++) begin
                logic fs_s, fs_p, trig, es, ew;
                string tg;
                tick();
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[1:0] == 2'b00) fsync_in = ~fsync_in;
                div_clk_in     = lf[12];
                tx_start_pulse = (lf[5:3] == 3'b101);
                cmp0_pulse     = (lf[8:6] == 3'b011);
                xfer_done      = (lf[11:9] == 3'b000);
                rx_enable      = !(i >= 100 && i < 110);
                #1;
                fs_s = h2[3];
                fs_p = h3[3];
                case (code)
                    0: trig = 1'b1;
                    1: trig = tx_start_pulse;
                    2: trig = ~fs_s;
                    3: trig = fs_s;
                    4: trig = fs_p & ~fs_s;
                    5: trig = ~fs_p & fs_s;
                    6, 7: trig = fs_p ^ fs_s;
                    8: trig = cmp0_pulse;
                    default: trig = 1'b0;
                endcase
                es = rx_enable & ~mbusy & trig;
                ew = es | mbusy;
                if (!rx_enable)      tg = "R7";
                else if (mbusy)      tg = "R6";
                else if (code == 0)  tg = "R1";
                else if (code == 1 || code == 8) tg = "R2";
                else if (code <= 3)  tg = "R3";
                else if (code <= 7)  tg = "R4";
                else                 tg = "R5";
                check(tg, "start_pulse", start_pulse, es);
                check("R12", "rx_clk_oe", rx_clk_oe, ew);
                check("R12", "rx_clk_out", rx_clk_out, ew & h2[0]);
                if (!rx_enable)   mbusy = 1'b0;
                else if (es)      mbusy = 1'b1;
                else if (xfer_done) mbusy = 1'b0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule